// File: doc/BRIEF.md
# Multi-Domain Reset Sequencer

This block drives three active-low reset lines for a processor core: the core logic, the debug logic and a SIMD engine. It also drives a clock-enable for the core clock and a clock-stop line for the SIMD engine. A one-cycle request on `req_valid` with a code on `req_mode` starts a timed sequence. The sequence asserts the selected resets while the clock still runs, holds them, stops the clock, waits, releases the resets with the clock stopped, waits again, and only then lets the clock run. Every counter runs on the free-running reference clock `clk`, so the waits still elapse while the core clock is gated off.

The power-on input `por_n` drops every output into its reset state at once, with no clock edge needed. Its release passes through a synchronizer, and the controller then works through a full cold sequence. A request that arrives while a sequence is running is held and carried out after the sequence has finished. A held cold request is never displaced by a later, weaker one.

The parameter `SIMD_PRESENT` selects whether the SIMD engine exists. Without it, the SIMD reset line simply copies the core reset line and the SIMD clock-stop line stays low.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_n` is low, all three resets are low, `core_clk_en` is low, `busy` is high and `done` is low; `simd_clk_stop` is high only when `SIMD_PRESENT` is 1. Once `por_n` has been released, a full cold sequence runs and ends with a `done` pulse.
- R2: In every sequence, the selected resets are held low with the core clock enabled for exactly `HOLD_CYC` cycles (default 15, at least 9) before the clock-stop window begins.
- R3: After the hold, the clock-stop window lasts `SETTLE_A` cycles with the resets still low. Then all resets go high while the clock stays stopped for `SETTLE_B` more cycles, and after that `core_clk_en` returns high. A reset never rises while `core_clk_en` is high.
- R4: `req_mode` encodes 0 cold (core, SIMD and debug low), 1 warm (core and SIMD low), 2 SIMD-only (SIMD low) and 3 debug-only (debug low). The resets not selected stay high for the whole sequence.
- R5: During a warm sequence `dbg_rst_n` stays high in every cycle.
- R6: In a SIMD-only sequence `core_clk_en` stays high. `simd_clk_stop` is high for the `SETTLE_A + SETTLE_B` stop cycles whenever the SIMD reset is part of the pattern (cold, warm, SIMD-only).
- R7: With `SIMD_PRESENT` = 0, `simd_rst_n` always equals `core_rst_n` and `simd_clk_stop` is always low. All other outputs behave exactly as with the engine present.
- R8: A request that arrives while `busy` is high does not change the running sequence. The held request starts the next sequence in the cycle right after the `done` cycle. If several non-cold requests arrive, the latest one is kept.
- R9: A held cold request is not replaced by a later warm, SIMD-only or debug-only request, and those later requests are dropped.
- R10: `done` is high for exactly one cycle, in the first cycle with the clock running again. `busy` falls in that same cycle.
- R11: A request sampled at clock edge k is held. Its sequence's outputs first change at edge k+1, provided the controller was idle.
- R12: `por_n` going low forces the reset state without waiting for a clock edge. After `por_n` rises, the outputs keep their reset values for three more edges (two synchronizer stages plus the state register), and then the hold phase begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| req_valid | input | 1 | One-cycle reset request strobe |
| req_mode | input | 2 | Requested pattern: 0 cold, 1 warm, 2 SIMD-only, 3 debug-only |
| core_rst_n | output | 1 | Core logic reset, active low |
| simd_rst_n | output | 1 | SIMD engine reset, active low |
| dbg_rst_n | output | 1 | Debug logic reset, active low |
| core_clk_en | output | 1 | Enable for the gated core clock |
| simd_clk_stop | output | 1 | Stop request for the SIMD engine clock |
| busy | output | 1 | High from acceptance of a request until the clock is running again |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bound checker checks the timing rules on every cycle:
- the hold is at least `HOLD_CYC` cycles long before the clock stops;
- the clock stops only while a reset is held;
- a reset is released only while its clock is stopped;
- the debug reset stays high through a warm sequence;
- `done` is a single pulse that coincides with the fall of `busy`;
- the SIMD lines track the core line when the engine is absent.

Other behaviours can only be shown by the bench's scenarios: the exact mask of each mode, the length of each phase, the one-cycle request latency, the queuing of a request behind a running sequence together with cold priority and latest-wins among weaker requests, and the immediate effect of an asynchronous power-on reset in the middle of a cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        REQ_COLD  = 2'd0,
        REQ_WARM  = 2'd1,
        REQ_SIMD  = 2'd2,
        REQ_DEBUG = 2'd3
    } req_mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_STOP = 2'd2,
        ST_REL  = 2'd3
    } seq_st_e;

    // Registered domain outputs; reset fields are active low
    typedef struct packed {
        logic core_n;
        logic simd_n;
        logic dbg_n;
        logic clk_en;
        logic simd_stop;
    } dom_out_t;

    // Which domains a mode pulls into reset: {core, simd, debug}
    function automatic logic [2:0] assert_mask(req_mode_e m);
        logic [2:0] r;
        case (m)
            REQ_COLD:  r = 3'b111;
            REQ_WARM:  r = 3'b110;
            REQ_SIMD:  r = 3'b010;
            default:   r = 3'b001;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    assign chain_d[0] = 1'b1;

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            assign chain_d[i] = chain_q[i-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_pending.sv
module rstseq_pending
    import rstseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic [1:0] req_mode,
    input  logic      take,
    output logic      pend_valid,
    output req_mode_e pend_mode
);
    typedef struct packed {
        logic      vld;
        req_mode_e mode;
    } pend_t;

    pend_t pend_d;
    pend_t pend_q;
    logic  keep;

    always_comb begin
        keep       = pend_q.vld && !take;
        pend_d     = pend_q;
        pend_d.vld = req_valid || keep;
        // a held cold request survives any later, weaker request
        if (req_valid && (!keep || pend_q.mode != REQ_COLD)) begin
            pend_d.mode = req_mode_e'(req_mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q.vld  <= 1'b0;
            pend_q.mode <= REQ_COLD;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_valid = pend_q.vld;
    assign pend_mode  = pend_q.mode;
endmodule

// File: rtl/rstseq_outmap.sv
module rstseq_outmap
    import rstseq_pkg::*;
#(
    parameter bit SIMD_PRESENT = 1'b1
) (
    input  seq_st_e   st,
    input  req_mode_e mode,
    output dom_out_t  dom
);
    logic [2:0] mask;
    logic       hold_win;
    logic       stop_win;
    logic       core_n;

    assign mask     = assert_mask(mode);
    assign hold_win = (st == ST_HOLD) || (st == ST_STOP);
    assign stop_win = (st == ST_STOP) || (st == ST_REL);
    assign core_n   = !(hold_win && mask[2]);

    assign dom.core_n = core_n;
    assign dom.dbg_n  = !(hold_win && mask[0]);
    // core clock stops unless only the SIMD engine is being reset
    assign dom.clk_en = !(stop_win && (mask[2] || mask[0]));

    generate
        if (SIMD_PRESENT) begin : g_simd
            assign dom.simd_n    = !(hold_win && mask[1]);
            assign dom.simd_stop = stop_win && mask[1];
        end else begin : g_no_simd
            logic unused_simd;
            assign unused_simd   = mask[1];
            assign dom.simd_n    = core_n;
            assign dom.simd_stop = 1'b0 & unused_simd;
        end
    endgenerate
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYC     = 15,
    parameter int SETTLE_A     = 10,
    parameter int SETTLE_B     = 10,
    parameter bit SIMD_PRESENT = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pend_valid,
    input  req_mode_e pend_mode,
    input  dom_out_t  dom_nxt,
    output logic      take,
    output seq_st_e   st_nxt,
    output req_mode_e mode_nxt,
    output dom_out_t  dom,
    output req_mode_e mode,
    output logic      busy,
    output logic      done
);
    localparam int MAX_AB = (SETTLE_A > SETTLE_B) ? SETTLE_A : SETTLE_B;
    localparam int MAX_V  = (HOLD_CYC > MAX_AB) ? HOLD_CYC : MAX_AB;
    localparam int CW     = $clog2(MAX_V + 1);

    typedef struct packed {
        seq_st_e       st;
        req_mode_e     mode;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
        dom_out_t      dom;
    } fsm_t;

    fsm_t s_d;
    fsm_t s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        take     = 1'b0;
        case (s_q.st)
            ST_RUN: begin
                if (pend_valid) begin
                    take     = 1'b1;
                    s_d.st   = ST_HOLD;
                    s_d.mode = pend_mode;
                    s_d.cnt  = CW'(HOLD_CYC - 1);
                    s_d.busy = 1'b1;
                end
            end
            ST_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_STOP;
                    s_d.cnt = CW'(SETTLE_A - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_STOP: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_REL;
                    s_d.cnt = CW'(SETTLE_B - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = ST_RUN;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        endcase
        s_d.dom = dom_nxt;
    end

    assign st_nxt   = s_d.st;
    assign mode_nxt = s_d.mode;

    // Power-up lands in the hold phase of a cold sequence; one extra count
    // covers the first cycle in which the clock is still off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st            <= ST_HOLD;
            s_q.mode          <= REQ_COLD;
            s_q.cnt           <= CW'(HOLD_CYC);
            s_q.busy          <= 1'b1;
            s_q.done          <= 1'b0;
            s_q.dom.core_n    <= 1'b0;
            s_q.dom.simd_n    <= 1'b0;
            s_q.dom.dbg_n     <= 1'b0;
            s_q.dom.clk_en    <= 1'b0;
            s_q.dom.simd_stop <= SIMD_PRESENT;
        end else begin
            s_q <= s_d;
        end
    end

    assign dom  = s_q.dom;
    assign mode = s_q.mode;
    assign busy = s_q.busy;
    assign done = s_q.done;
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYC     = 15,
    parameter int SETTLE_A     = 10,
    parameter int SETTLE_B     = 10,
    parameter int SYNC_STAGES  = 2,
    parameter bit SIMD_PRESENT = 1'b1
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    output logic       core_rst_n,
    output logic       simd_rst_n,
    output logic       dbg_rst_n,
    output logic       core_clk_en,
    output logic       simd_clk_stop,
    output logic       busy,
    output logic       done
);
    logic      rst_sync_n;
    logic      pend_valid;
    req_mode_e pend_mode;
    logic      take;
    seq_st_e   st_nxt;
    req_mode_e mode_nxt;
    req_mode_e seq_mode;
    dom_out_t  dom_nxt;
    dom_out_t  dom;

    rstseq_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .arst_n (por_n),
        .rst_n  (rst_sync_n)
    );

    rstseq_pending i_pend (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_mode  (pend_mode)
    );

    rstseq_outmap #(.SIMD_PRESENT(SIMD_PRESENT)) i_map (
        .st   (st_nxt),
        .mode (mode_nxt),
        .dom  (dom_nxt)
    );

    rstseq_fsm #(
        .HOLD_CYC     (HOLD_CYC),
        .SETTLE_A     (SETTLE_A),
        .SETTLE_B     (SETTLE_B),
        .SIMD_PRESENT (SIMD_PRESENT)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .pend_valid (pend_valid),
        .pend_mode  (pend_mode),
        .dom_nxt    (dom_nxt),
        .take       (take),
        .st_nxt     (st_nxt),
        .mode_nxt   (mode_nxt),
        .dom        (dom),
        .mode       (seq_mode),
        .busy       (busy),
        .done       (done)
    );

    assign core_rst_n    = dom.core_n;
    assign simd_rst_n    = dom.simd_n;
    assign dbg_rst_n     = dom.dbg_n;
    assign core_clk_en   = dom.clk_en;
    assign simd_clk_stop = dom.simd_stop;
endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk #(
    parameter int HOLD_CYC     = 15,
    parameter bit SIMD_PRESENT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       core_rst_n,
    input logic       simd_rst_n,
    input logic       dbg_rst_n,
    input logic       core_clk_en,
    input logic       simd_clk_stop,
    input logic       busy,
    input logic       done,
    input logic [1:0] seq_mode
);
    logic [15:0] held_run;

    // cycles with core reset held while the clock runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        held_run <= '0;
        else if (core_rst_n)               held_run <= '0;
        else if (core_clk_en && held_run != 16'hFFFF) held_run <= held_run + 16'd1;
    end

    AST_HOLD_BEFORE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_clk_en) && !core_rst_n) |-> (32'(held_run) >= HOLD_CYC)); // R2

    AST_STOP_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |-> (!core_rst_n || !dbg_rst_n)); // R3

    AST_RELEASE_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_rst_n) || $rose(dbg_rst_n)) |-> !core_clk_en); // R3

    AST_SIMD_RELEASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(simd_rst_n) |-> (simd_clk_stop || !core_clk_en)); // R6

    AST_WARM_KEEPS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_mode == 2'd1) |-> dbg_rst_n); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && core_clk_en)); // R10

    generate
        if (!SIMD_PRESENT) begin : g_absent
            AST_SIMD_FOLLOWS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
                (simd_rst_n == core_rst_n) && !simd_clk_stop); // R7
        end
    endgenerate
endmodule

bind rstseq_ctrl rstseq_ctrl_chk #(
    .HOLD_CYC     (HOLD_CYC),
    .SIMD_PRESENT (SIMD_PRESENT)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .core_rst_n    (core_rst_n),
    .simd_rst_n    (simd_rst_n),
    .dbg_rst_n     (dbg_rst_n),
    .core_clk_en   (core_clk_en),
    .simd_clk_stop (simd_clk_stop),
    .busy          (busy),
    .done          (done),
    .seq_mode      (seq_mode)
);

// File: tb/test_rstseq_ctrl.sv
module test_rstseq_ctrl;
    localparam int HOLD = 15;
    localparam int SA   = 10;
    localparam int SB   = 10;
    localparam int PH_RESET = 0, PH_HOLD = 1, PH_STOP = 2, PH_REL = 3, PH_DONE = 4, PH_IDLE = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       por_n     = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode  = 2'd0;

    logic core_rst_n, simd_rst_n, dbg_rst_n, core_clk_en, simd_clk_stop, busy, done;
    logic n_core, n_simd, n_dbg, n_clk_en, n_stop, n_busy, n_done;

    rstseq_ctrl #(.HOLD_CYC(HOLD), .SETTLE_A(SA), .SETTLE_B(SB), .SIMD_PRESENT(1'b1)) i_rstseq_ctrl (
        .clk(clk), .por_n(por_n), .req_valid(req_valid), .req_mode(req_mode),
        .core_rst_n(core_rst_n), .simd_rst_n(simd_rst_n), .dbg_rst_n(dbg_rst_n),
        .core_clk_en(core_clk_en), .simd_clk_stop(simd_clk_stop), .busy(busy), .done(done)
    );

    rstseq_ctrl #(.HOLD_CYC(HOLD), .SETTLE_A(SA), .SETTLE_B(SB), .SIMD_PRESENT(1'b0)) i_rstseq_ctrl_nosimd (
        .clk(clk), .por_n(por_n), .req_valid(req_valid), .req_mode(req_mode),
        .core_rst_n(n_core), .simd_rst_n(n_simd), .dbg_rst_n(n_dbg),
        .core_clk_en(n_clk_en), .simd_clk_stop(n_stop), .busy(n_busy), .done(n_done)
    );

    typedef struct {
        logic [6:0] vec;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int errors = 0;
    int checks = 0;

    function automatic logic [6:0] actual();
        return {core_rst_n, simd_rst_n, dbg_rst_n, core_clk_en, simd_clk_stop, busy, done};
    endfunction

    // {core, simd, debug} pulled low per mode code
    function automatic logic [2:0] mask_of(logic [1:0] m);
        case (m)
            2'd0:    return 3'b111;
            2'd1:    return 3'b110;
            2'd2:    return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [6:0] vec_for(int ph, logic [1:0] m);
        logic [2:0] mk;
        logic       ce;
        mk = mask_of(m);
        ce = (m == 2'd2);
        case (ph)
            PH_RESET: return 7'b000_0_1_1_0;
            PH_HOLD:  return {~mk, 1'b1, 1'b0, 1'b1, 1'b0};
            PH_STOP:  return {~mk, ce, mk[1], 1'b1, 1'b0};
            PH_REL:   return {3'b111, ce, mk[1], 1'b1, 1'b0};
            PH_DONE:  return 7'b111_1_0_0_1;
            default:  return 7'b111_1_0_0_0;
        endcase
    endfunction

    task automatic push(int ph, logic [1:0] m, string tag, int n);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.vec = vec_for(ph, m);
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic push_body(logic [1:0] m, string tag);
        push(PH_HOLD, m, tag, HOLD);
        push(PH_STOP, m, "R3", SA);
        push(PH_REL,  m, "R3", SB);
        push(PH_DONE, m, "R10", 1);
    endtask

    task automatic direct_check(logic [6:0] exp, string tag);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s: outputs act=%b exp=%b at %0t", tag, actual(), exp, $time);
        end
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(posedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (actual() !== it.vec) begin
                errors++;
                $display("FAIL %s: outputs act=%b exp=%b at %0t", it.tag, actual(), it.vec, $time);
            end
            checks++;
            if ({n_core, n_dbg, n_clk_en, n_busy, n_done} !== {core_rst_n, dbg_rst_n, core_clk_en, busy, done}
                || n_simd !== n_core || n_stop !== 1'b0) begin
                errors++;
                $display("FAIL R7: no-SIMD outputs act=%b%b%b%b%b%b%b exp=%b%b%b%b%b%b%b at %0t",
                         n_core, n_simd, n_dbg, n_clk_en, n_stop, n_busy, n_done,
                         core_rst_n, core_rst_n, dbg_rst_n, core_clk_en, 1'b0, busy, done, $time);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic request(logic [1:0] m, string tag);
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_mode  = m;
        push(PH_IDLE, m, "R11", 2);
        push_body(m, tag);
        push(PH_IDLE, m, "R11", 1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        drain();
    endtask

    initial begin
        // R1 reset state while por_n low
        repeat (3) begin
            @(negedge clk);
            direct_check(7'b000_0_1_1_0, "R1");
        end
        @(posedge clk);
        #1;
        por_n = 1'b1;
        push(PH_RESET, 2'd0, "R12", 3);
        push_body(2'd0, "R1");
        push(PH_IDLE, 2'd0, "R10", 2);
        drain();

        // R4 R5 R6 each pattern from idle
        request(2'd1, "R5");
        request(2'd0, "R4");
        request(2'd2, "R6");
        request(2'd3, "R4");

        // R9: SIMD-only running; cold then warm arrive, cold must run next
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_mode  = 2'd2;
        push(PH_IDLE, 2'd2, "R11", 2);
        push_body(2'd2, "R8");
        push_body(2'd0, "R9");
        push(PH_IDLE, 2'd0, "R9", 4);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        repeat (8) @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_mode  = 2'd0;
        @(posedge clk);
        #1;
        req_mode  = 2'd1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        drain();

        // R8: debug running; warm then SIMD-only arrive, latest wins
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_mode  = 2'd3;
        push(PH_IDLE, 2'd3, "R11", 2);
        push_body(2'd3, "R8");
        push_body(2'd2, "R8");
        push(PH_IDLE, 2'd2, "R8", 3);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_mode  = 2'd1;
        @(posedge clk);
        #1;
        req_mode  = 2'd2;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        drain();

        // R12: asynchronous power-on reset mid-cycle
        @(posedge clk);
        #2;
        por_n = 1'b0;
        #1;
        direct_check(7'b000_0_1_1_0, "R12");
        @(negedge clk);
        direct_check(7'b000_0_1_1_0, "R1");
        @(posedge clk);
        #1;
        por_n = 1'b1;
        push(PH_RESET, 2'd0, "R12", 3);
        push_body(2'd0, "R1");
        push(PH_IDLE, 2'd0, "R10", 2);
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule